// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes characters from a receive channel and writes them into memory buffers. Each buffer is described by one entry in a circular table of descriptors. The table sits in a small on-chip RAM, and both software and the engine can reach it. When a character arrives and no buffer is open, the engine opens the buffer named by the current descriptor. It then writes the character to the buffer's address and moves a byte pointer forward. It also counts down the bytes still free in the buffer.

A buffer closes in three cases: its capacity runs out, the character carries an end-of-frame mark, or the character carries an error mark. On close, the engine writes the byte count and the close reason back into the descriptor and hands the descriptor back to software. It then moves to the next descriptor. After the descriptor marked as last, it returns to the table base.

Software sets up three values through a small register port: the table base, the buffer capacity and the current-descriptor pointer. It prepares descriptors through the RAM port. The capacity is sampled only when a buffer opens, so a write to it never changes a buffer that is already being filled.

Top module: `rx_bd_ring`

## Requirements
- R1: After reset, `cur_ptr` equals the base reset value with its low three bits cleared, and `wr_valid`, `busy` and `cfg_err` are 0.
- R2: A character accepted on a rising edge shows up on `wr_valid`/`wr_addr`/`wr_data` one cycle later. The first character of a buffer goes to the descriptor's buffer address, and each later character goes to the address one higher.
- R3: A buffer closes on the character that uses up the capacity sampled at open. Write-back sets the length halfword to the byte count and clears the empty bit (status bit 15). The pointer then advances by 8 bytes.
- R4: A character marked end-of-frame closes the buffer early and sets status bit 11. A character marked error closes it early and sets status bit 1. The wrap bit (bit 13) is kept.
- R5: A descriptor occupies 4 halfwords at halfword index slot*4. They are, in order: status (bit 15 empty, bit 13 wrap), length, buffer address high, buffer address low. After closing a descriptor that has the wrap bit set, `cur_ptr` returns to the table base.
- R6: A write with `cfg_sel`=0 sets the table base. The low three bits of the written value are ignored.
- R7: A write with `cfg_sel`=1 sets the capacity. The new value applies from the next buffer that opens, never to the open one.
- R8: A write with `cfg_sel`=2 sets the current pointer (low three bits cleared). It is ignored while `rx_en` is 1 and a buffer is open.
- R9: If a character arrives while no buffer is open and the current descriptor is not empty, the character is dropped and `busy` pulses for one cycle, one cycle later.
- R10: While `rx_en` is 0, characters are ignored. They cause no memory write and no `busy` pulse.
- R11: A capacity write of zero is ignored and `cfg_err` pulses one cycle later. When `CHAR_W` exceeds 8, an odd capacity is treated the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_valid | input | 1 | A character is present this cycle |
| rx_data | input | CHAR_W | Received character |
| rx_eof | input | 1 | Character ends a frame |
| rx_err | input | 1 | Character carries an error |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 capacity, 2 current pointer |
| cfg_wdata | input | 16 | Register write data |
| sw_we | input | 1 | Descriptor RAM write strobe |
| sw_addr | input | TBL_AW-1 | Descriptor RAM halfword index |
| sw_wdata | input | 16 | Descriptor RAM write data |
| sw_rdata | output | 16 | Descriptor RAM read data (combinational) |
| wr_valid | output | 1 | Memory byte write request |
| wr_addr | output | BUF_AW | Memory byte address |
| wr_data | output | CHAR_W | Memory byte data |
| busy | output | 1 | Character dropped for lack of an empty descriptor |
| cfg_err | output | 1 | Rejected capacity write |
| cur_ptr | output | TBL_AW | Current descriptor byte address |

## Verification
The outputs fall into two timing groups. The memory write request, `busy`, `cfg_err` and `cur_ptr` come from registers, so each is due one edge after the input that caused it. Descriptor write-back can be read combinationally through `sw_rdata` as soon as that same edge has passed. Every stimulus is applied at a falling edge and held across exactly one rising edge, and the results are sampled at the following falling edge. For RAM reads, the bench waits a short delay after setting the halfword index.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ST_EMPTY = 15;
   localparam int ST_WRAP  = 13;
   localparam int ST_FRAME = 11;
   localparam int ST_ERR   = 1;

   typedef enum logic [1:0] {
      SEL_BASE   = 2'd0,
      SEL_MAXLEN = 2'd1,
      SEL_CUR    = 2'd2
   } cfg_sel_e;
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs #(
   parameter int TBL_AW   = 8,
   parameter int LEN_W    = 16,
   parameter int CHAR_W   = 8,
   parameter int BASE_RST = 0,
   parameter int LEN_RST  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              len_we,
   input  logic [15:0]       wdata,
   output logic [TBL_AW-4:0] base_slot,
   output logic [LEN_W-1:0]  maxlen,
   output logic              cfg_err
);
   localparam logic [TBL_AW-1:0] BASE_B = TBL_AW'(BASE_RST);
   localparam logic [LEN_W-1:0]  LEN_B  = LEN_W'(LEN_RST);

   logic [LEN_W-1:0] len_in;
   logic             len_ok;

   assign len_in = wdata[LEN_W-1:0];

   generate
      if (CHAR_W > 8) begin : g_wide
         assign len_ok = (len_in != '0) && !len_in[0];
      end else begin : g_narrow
         assign len_ok = (len_in != '0);
      end
      if (LEN_RST == 0) begin : g_bad_rst
         $error("capacity reset value must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_slot <= BASE_B[TBL_AW-1:3];
         maxlen    <= LEN_B;
         cfg_err   <= 1'b0;
      end else begin
         cfg_err <= len_we && !len_ok;
         if (base_we) base_slot <= wdata[TBL_AW-1:3];
         if (len_we && len_ok) maxlen <= len_in;
      end
   end

   // R11
   maxlen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      maxlen != '0);
   // R11
   reject_keeps_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $stable(maxlen));
endmodule

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
   parameter int TBL_AW = 8
) (
   input  logic              clk,
   input  logic              sw_we,
   input  logic [TBL_AW-2:0] sw_idx,
   input  logic [15:0]       sw_wdata,
   output logic [15:0]       sw_rdata,
   input  logic              eng_we,
   input  logic [TBL_AW-4:0] eng_slot,
   input  logic [15:0]       eng_status,
   input  logic [15:0]       eng_len,
   input  logic [TBL_AW-4:0] rd_slot,
   output logic [15:0]       rd_status,
   output logic [31:0]       rd_addr
);
   localparam int HW_N = 2 ** (TBL_AW - 1);

   logic [15:0] mem [HW_N];

   always_ff @(posedge clk) begin
      if (sw_we) mem[sw_idx] <= sw_wdata;
      if (eng_we) begin
         mem[{eng_slot, 2'd0}] <= eng_status;
         mem[{eng_slot, 2'd1}] <= eng_len;
      end
   end

   assign sw_rdata  = mem[sw_idx];
   assign rd_status = mem[{rd_slot, 2'd0}];
   assign rd_addr   = {mem[{rd_slot, 2'd2}], mem[{rd_slot, 2'd3}]};
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int TBL_AW   = 8,
   parameter int LEN_W    = 16,
   parameter int BUF_AW   = 32,
   parameter int CHAR_W   = 8,
   parameter int BASE_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic [TBL_AW-4:0] base_slot,
   input  logic [LEN_W-1:0]  maxlen,
   input  logic              cp_we,
   input  logic [TBL_AW-4:0] cp_slot,
   input  logic [15:0]       d_status,
   input  logic [31:0]       d_addr,
   output logic [TBL_AW-4:0] cur_slot,
   output logic              wb_we,
   output logic [15:0]       wb_status,
   output logic [15:0]       wb_len,
   output logic              wr_valid,
   output logic [BUF_AW-1:0] wr_addr,
   output logic [CHAR_W-1:0] wr_data,
   output logic              busy
);
   localparam logic [TBL_AW-1:0] BASE_B = TBL_AW'(BASE_RST);
   localparam logic [15:0] CLR_MASK =
      ~((16'd1 << ST_EMPTY) | (16'd1 << ST_FRAME) | (16'd1 << ST_ERR));

   logic              open_q;
   logic [LEN_W-1:0]  left_q;
   logic [LEN_W-1:0]  n_q;
   logic [BUF_AW-1:0] bptr_q;

   logic              take, avail, accept, drop, close, wrap;
   logic [LEN_W-1:0]  left_eff, left_nx, n_nx;
   logic [BUF_AW-1:0] ptr_eff;

   assign take     = rx_valid && rx_en;
   assign avail    = open_q || d_status[ST_EMPTY];
   assign accept   = take && avail;
   assign drop     = take && !avail;
   assign wrap     = d_status[ST_WRAP];
   assign left_eff = open_q ? left_q : maxlen;
   assign ptr_eff  = open_q ? bptr_q : d_addr[BUF_AW-1:0];
   assign left_nx  = left_eff - LEN_W'(1);
   assign n_nx     = (open_q ? n_q : '0) + LEN_W'(1);
   assign close    = accept && ((left_nx == '0) || rx_eof || rx_err);

   assign wb_we     = close;
   assign wb_len    = 16'(n_nx);
   assign wb_status = (d_status & CLR_MASK)
                    | (rx_eof ? (16'd1 << ST_FRAME) : 16'd0)
                    | (rx_err ? (16'd1 << ST_ERR)   : 16'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         left_q   <= '0;
         n_q      <= '0;
         bptr_q   <= '0;
         cur_slot <= BASE_B[TBL_AW-1:3];
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         busy     <= 1'b0;
      end else begin
         wr_valid <= accept;
         busy     <= drop;
         if (accept) begin
            wr_addr <= ptr_eff;
            wr_data <= rx_data;
            bptr_q  <= ptr_eff + BUF_AW'(1);
            left_q  <= left_nx;
            n_q     <= n_nx;
            open_q  <= !close;
         end
         if (close) begin
            cur_slot <= wrap ? base_slot : cur_slot + 1'b1;
         end else if (cp_we && (!rx_en || !open_q) && !accept) begin
            cur_slot <= cp_slot;
         end
      end
   end

   // R3
   room_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (left_q != '0));
   // R5
   wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (close && wrap) |=> (cur_slot == $past(base_slot)));
   // R8
   ptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_we && rx_en && open_q && !accept) |=> $stable(cur_slot));
   // R9
   drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_valid);
   // R10
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_en) |-> (!wr_valid && !busy));
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
   import rxr_pkg::*;
#(
   parameter int TBL_AW   = 8,
   parameter int LEN_W    = 16,
   parameter int BUF_AW   = 32,
   parameter int CHAR_W   = 8,
   parameter int BASE_RST = 0,
   parameter int LEN_RST  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [15:0]       cfg_wdata,
   input  logic              sw_we,
   input  logic [TBL_AW-2:0] sw_addr,
   input  logic [15:0]       sw_wdata,
   output logic [15:0]       sw_rdata,
   output logic              wr_valid,
   output logic [BUF_AW-1:0] wr_addr,
   output logic [CHAR_W-1:0] wr_data,
   output logic              busy,
   output logic              cfg_err,
   output logic [TBL_AW-1:0] cur_ptr
);
   generate
      if (TBL_AW < 4 || TBL_AW > 16) begin : g_bad_tbl
         $error("TBL_AW must lie in 4..16");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (BUF_AW < 1 || BUF_AW > 32) begin : g_bad_buf
         $error("BUF_AW must lie in 1..32");
      end
   endgenerate

   logic [TBL_AW-4:0] base_slot, cur_slot;
   logic [LEN_W-1:0]  maxlen;
   logic              wb_we;
   logic [15:0]       wb_status, wb_len, d_status;
   logic [31:0]       d_addr;
   logic              base_we, len_we, cp_we;

   assign base_we = cfg_we && (cfg_sel == SEL_BASE);
   assign len_we  = cfg_we && (cfg_sel == SEL_MAXLEN);
   assign cp_we   = cfg_we && (cfg_sel == SEL_CUR);
   assign cur_ptr = {cur_slot, 3'b000};

   rxr_cfg_regs #(
      .TBL_AW(TBL_AW), .LEN_W(LEN_W), .CHAR_W(CHAR_W),
      .BASE_RST(BASE_RST), .LEN_RST(LEN_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .len_we(len_we),
      .wdata(cfg_wdata), .base_slot(base_slot), .maxlen(maxlen),
      .cfg_err(cfg_err)
   );

   rxr_desc_ram #(.TBL_AW(TBL_AW)) u_ram (
      .clk(clk), .sw_we(sw_we), .sw_idx(sw_addr), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .eng_we(wb_we), .eng_slot(cur_slot),
      .eng_status(wb_status), .eng_len(wb_len), .rd_slot(cur_slot),
      .rd_status(d_status), .rd_addr(d_addr)
   );

   rxr_engine #(
      .TBL_AW(TBL_AW), .LEN_W(LEN_W), .BUF_AW(BUF_AW),
      .CHAR_W(CHAR_W), .BASE_RST(BASE_RST)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
      .base_slot(base_slot), .maxlen(maxlen), .cp_we(cp_we),
      .cp_slot(cfg_wdata[TBL_AW-1:3]), .d_status(d_status), .d_addr(d_addr),
      .cur_slot(cur_slot), .wb_we(wb_we), .wb_status(wb_status),
      .wb_len(wb_len), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy)
   );
endmodule

// File: tb/tb_rx_bd_ring.sv
module tb_rx_bd_ring;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        sw_we = 1'b0;
   logic [6:0]  sw_addr = '0;
   logic [15:0] sw_wdata = '0;
   logic [15:0] sw_rdata;
   logic        wr_valid, busy, cfg_err;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;
   logic [7:0]  cur_ptr;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   rx_bd_ring dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .cfg_err(cfg_err), .cur_ptr(cur_ptr)
   );

   // {data, eof, err, expected address}
   localparam logic [25:0] VEC [7] = '{
      {8'hA0, 1'b0, 1'b0, 16'h1000},
      {8'hA1, 1'b0, 1'b0, 16'h1001},
      {8'hA2, 1'b0, 1'b0, 16'h1002},
      {8'hA3, 1'b0, 1'b0, 16'h1003},
      {8'hB0, 1'b0, 1'b0, 16'h2000},
      {8'hB1, 1'b1, 1'b0, 16'h2001},
      {8'hC0, 1'b0, 1'b1, 16'h3000}
   };

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [1:0] sel, input logic [15:0] v);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ram_wr(input logic [6:0] a, input logic [15:0] v);
      sw_we = 1'b1; sw_addr = a; sw_wdata = v;
      @(posedge clk); @(negedge clk);
      sw_we = 1'b0;
   endtask

   task automatic ram_chk(input string req, input logic [6:0] a,
                          input logic [15:0] exp, input string what);
      sw_addr = a; #1;
      chk(req, 32'(sw_rdata), 32'(exp), what);
   endtask

   task automatic send(input logic [7:0] d, input logic eof, input logic err);
      rx_valid = 1'b1; rx_data = d; rx_eof = eof; rx_err = err;
      @(posedge clk); @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", 32'(cur_ptr), 32'h00, "cur_ptr after reset");
      chk("R1", 32'(wr_valid), 0, "wr_valid after reset");
      chk("R1", 32'(busy), 0, "busy after reset");
      chk("R1", 32'(cfg_err), 0, "cfg_err after reset");
      rst_n = 1'b1;
      @(negedge clk);

      cfg_wr(2'd0, 16'h0010);
      cfg_wr(2'd2, 16'h0010);
      cfg_wr(2'd1, 16'd4);
      ram_wr(7'd8,  16'h8000); ram_wr(7'd10, 16'h0000); ram_wr(7'd11, 16'h1000);
      ram_wr(7'd12, 16'h8000); ram_wr(7'd14, 16'h0000); ram_wr(7'd15, 16'h2000);
      ram_wr(7'd16, 16'hA000); ram_wr(7'd18, 16'h0000); ram_wr(7'd19, 16'h3000);

      // R10 receiver disabled
      send(8'h55, 1'b0, 1'b0);
      chk("R10", 32'(wr_valid), 0, "write while disabled");
      chk("R10", 32'(busy), 0, "busy while disabled");
      rx_en = 1'b1;

      // R2 vector walk
      foreach (VEC[i]) begin
         send(VEC[i][25:18], VEC[i][17], VEC[i][16]);
         chk("R2", 32'(wr_valid), 1, "write request");
         chk("R2", wr_addr, 32'(VEC[i][15:0]), "write address");
         chk("R2", 32'(wr_data), 32'(VEC[i][25:18]), "write data");
      end
      ram_chk("R3", 7'd8, 16'h0000, "status after full close");
      ram_chk("R3", 7'd9, 16'd4, "length after full close");
      ram_chk("R4", 7'd12, 16'h0800, "status after frame end");
      ram_chk("R4", 7'd13, 16'd2, "length after frame end");
      ram_chk("R4", 7'd16, 16'h2002, "status after error");
      ram_chk("R4", 7'd17, 16'd1, "length after error");
      chk("R5", 32'(cur_ptr), 32'h10, "wrap to base");

      // R9 no empty descriptor
      send(8'h66, 1'b0, 1'b0);
      chk("R9", 32'(wr_valid), 0, "dropped byte written");
      chk("R9", 32'(busy), 1, "busy pulse");

      // R7 and R8: capacity change and pointer write during open buffer
      ram_wr(7'd8, 16'h8000);
      send(8'hE0, 1'b0, 1'b0);
      chk("R2", wr_addr, 32'h1000, "reopened address");
      cfg_wr(2'd2, 16'h0030);
      chk("R8", 32'(cur_ptr), 32'h10, "pointer write ignored");
      cfg_wr(2'd1, 16'd2);
      send(8'hE1, 1'b0, 1'b0);
      send(8'hE2, 1'b0, 1'b0);
      chk("R7", 32'(cur_ptr), 32'h10, "buffer still open after new capacity");
      send(8'hE3, 1'b0, 1'b0);
      chk("R7", wr_addr, 32'h1003, "fourth byte address");
      ram_chk("R7", 7'd9, 16'd4, "old capacity kept");
      chk("R3", 32'(cur_ptr), 32'h18, "advance by 8");
      ram_wr(7'd12, 16'h8000);
      send(8'hF0, 1'b0, 1'b0);
      send(8'hF1, 1'b0, 1'b0);
      ram_chk("R7", 7'd13, 16'd2, "new capacity used");
      chk("R7", 32'(cur_ptr), 32'h20, "closed at new capacity");

      // R8 accepted while disabled
      rx_en = 1'b0;
      cfg_wr(2'd2, 16'h0033);
      chk("R8", 32'(cur_ptr), 32'h30, "pointer write accepted");

      // R6 base masking, R11 zero capacity rejected
      cfg_wr(2'd0, 16'h000D);
      cfg_wr(2'd1, 16'd0);
      chk("R11", 32'(cfg_err), 1, "zero capacity flagged");
      cfg_wr(2'd2, 16'h0008);
      ram_wr(7'd4, 16'hA000); ram_wr(7'd6, 16'h0000); ram_wr(7'd7, 16'h4000);
      rx_en = 1'b1;
      send(8'hD0, 1'b0, 1'b0);
      chk("R2", wr_addr, 32'h4000, "first address of slot 1");
      send(8'hD1, 1'b0, 1'b0);
      ram_chk("R11", 7'd5, 16'd2, "capacity unchanged by zero write");
      ram_chk("R5", 7'd4, 16'h2000, "wrap bit kept, empty cleared");
      chk("R6", 32'(cur_ptr), 32'h08, "wrap to masked base");

      finish_run();
   end
endmodule